// File: doc/BRIEF.md
# Mode-Configurable Radix-4 Booth Multiplier

This block is a registered signed multiplier built from radix-4 Booth partial-product arrays. A 3-bit mode input picks the form of the operation. The form can be one 16x16 product, one 8x8 product on the low bytes, or two independent 8x8 products computed side by side on the high and low byte pairs. The lowest mode bit chooses between the exact product and a truncated product. A truncated product drops the low-order array columns and adds a constant rounding compensation before the kept half is taken.

Each partial-product row carries a single generated sign bit in place of a sign-extension run. The correction this leaves behind is folded into one precomputed constant. Arrays that the current form does not use have their operands held at zero. When an operand that the form consumes is zero, the result is forced to zero and the arithmetic result is ignored. The result register updates on the clock edge that samples `in_valid`, so there is one cycle of latency.

Top module: `cfg_booth_mul`

## Requirements
- R1: With mode[2:1] = 11 and mode[0] = 1, the 32-bit product is the signed product of op_a and op_b.
- R2: Mode[2:1] = 01 is reserved and gives exactly the results of mode[2:1] = 11, for both settings of mode[0].
- R3: With mode[2:1] = 10 and mode[0] = 1, the product is the signed product of op_a[7:0] and op_b[7:0], sign-extended to 32 bits. The high operand bytes have no effect.
- R4: With mode[2:1] = 00 and mode[0] = 1, product[31:16] is the signed product of op_a[15:8] and op_b[15:8], and product[15:0] is the signed product of op_a[7:0] and op_b[7:0].
- R5: With mode[0] = 0, the low half of each product field reads zero: bits [15:0] in the 16x16 forms, bits [7:0] in the single 8x8 form (with bits [31:16] still a sign extension of bit 15), and bits [7:0] and [23:16] in the dual form.
- R6: With mode[0] = 0, the difference between the exact product and the kept field, taken as a signed value, is at most 393216 in magnitude for a 16x16 product and at most 1024 for an 8x8 product.
- R7: In the single 8x8 form, if op_a[7:0] or op_b[7:0] is zero, the result is zero. In every other form, if op_a or op_b is zero, the result is zero. This holds in truncated mode too.
- R8: out_valid equals in_valid delayed by one clock. The product register loads only on a cycle with in_valid high and otherwise holds its value.
- R9: A synchronous active-high reset clears out_valid and product, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are sampled on this cycle |
| mode | input | 3 | [2:1] form select (11/01 full, 10 single byte, 00 dual byte), [0] 1 = exact, 0 = truncated |
| op_a | input | 16 | Signed operand A (two signed bytes in the dual form) |
| op_b | input | 16 | Signed operand B (two signed bytes in the dual form) |
| out_valid | output | 1 | Result register holds a fresh result |
| product | output | 32 | Registered result, laid out per the selected form |

## Verification
Zero shutdown and truncation can act in the same cycle. A truncated array fed zero operands does not by itself produce zero, because the rounding constant and the sign-bit correction leave a residue, so the shutdown must override the compensated result. The bench provokes this with directed truncated operations in every form where one operand is zero. It judges them by exact equality with zero. It also runs dual-form cases where only one lane's bytes are zero, which must not trigger shutdown. Randomised traffic then mixes both functions across all modes. Exact forms are compared with a behavioural signed multiply, and truncated forms are checked against the error bound.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    FORM_DUAL   = 2'b00,
    FORM_RSVD   = 2'b01,
    FORM_SINGLE = 2'b10,
    FORM_FULL   = 2'b11
  } form_e;

  // Sum of the sign-bit corrections of all rows, negated (two's complement).
  function automatic logic [63:0] booth_sign_const(input int w);
    logic [63:0] s;
    s = '0;
    for (int j = 0; j < w / 2; j++) begin
      s = s + (64'd1 << (w + 2 * j));
    end
    return -s;
  endfunction

endpackage

// File: rtl/cbm_zero_detect.sv
module cbm_zero_detect #(
  parameter int FULL = 16,
  parameter int HALF = 8
) (
  input  logic [FULL-1:0] a,
  input  logic [FULL-1:0] b,
  input  logic            low_only,
  output logic            zero_hit
);

  logic a_zero, b_zero;

  always_comb begin
    if (low_only) begin
      a_zero = (a[HALF-1:0] == '0);
      b_zero = (b[HALF-1:0] == '0);
    end else begin
      a_zero = (a == '0);
      b_zero = (b == '0);
    end
    zero_hit = a_zero | b_zero;
  end

endmodule

// File: rtl/cbm_booth_core.sv
module cbm_booth_core
  import cbm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           trunc,
  output logic [2*W-1:0] prod
);

  localparam int NPP = W / 2;
  localparam int PW  = 2 * W;
  localparam logic [63:0]   K64       = booth_sign_const(W);
  localparam logic [PW-1:0] SIGN_K    = K64[PW-1:0];
  localparam logic [PW-1:0] KEEP_MASK = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [PW-1:0] ROUND     = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [W:0]    bx;
  logic [PW-1:0] row  [NPP];
  logic [PW-1:0] nbit [NPP];

  assign bx = {b, 1'b0};

  for (genvar gj = 0; gj < NPP; gj++) begin : g_row
    logic [2:0] trip;
    logic [W:0] mag;
    logic [W:0] p;
    logic       neg;

    assign trip = bx[2*gj+2 : 2*gj];

    always_comb begin
      unique case (trip)
        3'b001, 3'b010: mag = {a[W-1], a};
        3'b101, 3'b110: mag = {a[W-1], a};
        3'b011, 3'b100: mag = {a, 1'b0};
        default:        mag = '0;
      endcase
      neg = trip[2] & ~(trip[1] & trip[0]);
      p   = neg ? ~mag : mag;
    end

    // Row value with one sign bit in place of a sign-extension run.
    assign row[gj]  = PW'({~p[W], p[W-1:0]}) << (2 * gj);
    assign nbit[gj] = PW'(neg) << (2 * gj);
  end

  logic [PW-1:0] mask;
  logic [PW-1:0] acc;

  always_comb begin
    mask = trunc ? KEEP_MASK : '1;
    acc  = SIGN_K & mask;
    for (int j = 0; j < NPP; j++) begin
      acc = acc + (row[j] & mask) + (nbit[j] & mask);
    end
    if (trunc) begin
      acc  = acc + ROUND;
      prod = {acc[PW-1:W], {W{1'b0}}};
    end else begin
      prod = acc;
    end
  end

endmodule

// File: rtl/cfg_booth_mul.sv
module cfg_booth_mul
  import cbm_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          mode,
  input  logic [2*HALF-1:0]   op_a,
  input  logic [2*HALF-1:0]   op_b,
  output logic                out_valid,
  output logic [4*HALF-1:0]   product
);

  localparam int FULL  = 2 * HALF;
  localparam int PW    = 2 * FULL;
  localparam int LANES = 2;

  form_e form;
  logic  is_full, is_single, is_dual, trunc;

  always_comb begin
    form      = form_e'(mode[2:1]);
    is_full   = (form == FORM_FULL) || (form == FORM_RSVD);
    is_single = (form == FORM_SINGLE);
    is_dual   = (form == FORM_DUAL);
    trunc     = ~mode[0];
  end

  // 16x16 array, operands held at zero when another form is selected.
  logic [FULL-1:0] fa, fb;
  logic [PW-1:0]   full_p;

  assign fa = is_full ? op_a : '0;
  assign fb = is_full ? op_b : '0;

  cbm_booth_core #(.W(FULL)) u_full (
    .a(fa), .b(fb), .trunc(trunc), .prod(full_p)
  );

  // Byte lanes: lane 0 serves the single and dual forms, lane 1 only the dual form.
  logic [LANES-1:0] lane_en;
  logic [FULL-1:0]  lane_p [LANES];

  assign lane_en[0] = is_single | is_dual;
  assign lane_en[1] = is_dual;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [HALF-1:0] la, lb;
    assign la = lane_en[gl] ? op_a[gl*HALF +: HALF] : '0;
    assign lb = lane_en[gl] ? op_b[gl*HALF +: HALF] : '0;
    cbm_booth_core #(.W(HALF)) u_core (
      .a(la), .b(lb), .trunc(trunc), .prod(lane_p[gl])
    );
  end

  logic zero_hit;

  cbm_zero_detect #(.FULL(FULL), .HALF(HALF)) u_zero (
    .a(op_a), .b(op_b), .low_only(is_single), .zero_hit(zero_hit)
  );

  logic [PW-1:0] result;

  always_comb begin
    if (is_full)        result = full_p;
    else if (is_single) result = {{(PW-FULL){lane_p[0][FULL-1]}}, lane_p[0]};
    else                result = {lane_p[1], lane_p[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= zero_hit ? '0 : result;
    end
  end

  // R9: reset leaves the outputs cleared
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && product == '0));

  // R8: one-cycle valid latency
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R8: no load without in_valid
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(product));

  // R7: zero operand forces a zero result
  assert_zero_shutdown_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(zero_hit)) |-> (product == '0));

  // R5: truncated full-width product has an empty low half
  assert_trunc_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(trunc && is_full))
      |-> (product[FULL-1:0] == '0));

endmodule

// File: tb/cfg_booth_mul_bench.sv
module cfg_booth_mul_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'b111;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfg_booth_mul u_cfg_booth_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic longint smul16(input logic [15:0] a, input logic [15:0] b);
    return longint'($signed(a)) * longint'($signed(b));
  endfunction

  function automatic longint smul8(input logic [7:0] a, input logic [7:0] b);
    return longint'($signed(a)) * longint'($signed(b));
  endfunction

  function automatic bit zero_in(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b);
    if (m[2:1] == 2'b10) return (a[7:0] == 8'h00) || (b[7:0] == 8'h00);
    return (a == 16'h0) || (b == 16'h0);
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_op(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b);
    string  tag;
    longint e, ex;
    logic [31:0] exp32;
    @(negedge clk);
    mode = m; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    op_a = 16'($urandom()); op_b = 16'($urandom());
    check(out_valid == 1'b1, "R8 valid", longint'(out_valid), 1);
    case (m[2:1])
      2'b11:   tag = "R1";
      2'b01:   tag = "R2";
      2'b10:   tag = "R3";
      default: tag = "R4";
    endcase
    if (zero_in(m, a, b)) begin
      check(product == 32'h0, "R7 zero operand", longint'(product), 0);
    end else if (m[0]) begin
      case (m[2:1])
        2'b11, 2'b01: exp32 = 32'(smul16(a, b));
        2'b10:        exp32 = 32'(smul8(a[7:0], b[7:0]));
        default:      exp32 = {16'(smul8(a[15:8], b[15:8])), 16'(smul8(a[7:0], b[7:0]))};
      endcase
      check(product == exp32, tag, longint'(product), longint'(exp32));
    end else begin
      case (m[2:1])
        2'b11, 2'b01: begin
          check(product[15:0] == 16'h0, {"R5 ", tag}, longint'(product[15:0]), 0);
          e = smul16(a, b) - longint'($signed(product));
          check(labs(e) <= 393216, {"R6 ", tag}, e, 393216);
        end
        2'b10: begin
          check(product[7:0] == 8'h0 && product[31:16] == {16{product[15]}},
                "R5 R3", longint'(product), 0);
          e = smul8(a[7:0], b[7:0]) - longint'($signed(product[15:0]));
          check(labs(e) <= 1024, "R6 R3", e, 1024);
        end
        default: begin
          check(product[7:0] == 8'h0 && product[23:16] == 8'h0, "R5 R4",
                longint'(product), 0);
          e  = smul8(a[7:0], b[7:0]) - longint'($signed(product[15:0]));
          ex = smul8(a[15:8], b[15:8]) - longint'($signed(product[31:16]));
          check(labs(e) <= 1024, "R6 R4 low lane", e, 1024);
          check(labs(ex) <= 1024, "R6 R4 high lane", ex, 1024);
        end
      endcase
    end
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    // R9: reset dominates active inputs
    in_valid = 1'b1; op_a = 16'h1234; op_b = 16'h0F0F; mode = 3'b111;
    repeat (3) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check(out_valid == 1'b0, "R9 out_valid", longint'(out_valid), 0);
    check(product == 32'h0, "R9 product", longint'(product), 0);

    // Directed exact corner cases
    run_op(3'b111, 16'h8000, 16'h8000);   // R1
    run_op(3'b111, 16'h8000, 16'h7FFF);   // R1
    run_op(3'b111, 16'hFFFF, 16'hFFFF);   // R1
    run_op(3'b011, 16'h8000, 16'h7FFF);   // R2
    run_op(3'b010, 16'h7FFF, 16'h8001);   // R2 truncated
    run_op(3'b101, 16'hAB80, 16'h3480);   // R3, high bytes ignored
    run_op(3'b101, 16'h0080, 16'h5580);   // R3 same low bytes, other high bytes
    run_op(3'b001, 16'h8080, 16'h807F);   // R4
    run_op(3'b001, 16'h00FF, 16'h12FF);   // R4 high lane zero, no shutdown
    // Truncated corners
    run_op(3'b110, 16'h8000, 16'h8000);   // R5 R6
    run_op(3'b100, 16'h0080, 16'h0080);   // R5 R6
    run_op(3'b000, 16'h807F, 16'h8081);   // R5 R6
    // Zero shutdown together with truncation, every form (R7)
    run_op(3'b110, 16'h0000, 16'h1234);
    run_op(3'b010, 16'hBEEF, 16'h0000);
    run_op(3'b100, 16'h5600, 16'h7799);
    run_op(3'b000, 16'h0000, 16'hFFFF);
    run_op(3'b111, 16'h0000, 16'h8000);
    run_op(3'b101, 16'h12AB, 16'hFF00);

    // R8: hold while idle
    run_op(3'b111, 16'h1357, 16'hFEDC);
    held = product;
    repeat (3) begin
      @(negedge clk);
      mode = 3'($urandom()); op_a = 16'($urandom()); op_b = 16'($urandom());
    end
    check(out_valid == 1'b0, "R8 idle valid", longint'(out_valid), 0);
    check(product == held, "R8 hold", longint'(product), longint'(held));

    // Constrained random across all modes
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      logic [2:0]  rm;
      rm = 3'($urandom());
      ra = 16'($urandom());
      rb = 16'($urandom());
      if ($urandom_range(0, 15) == 0) ra = '0;
      if ($urandom_range(0, 15) == 0) rb[7:0] = '0;
      run_op(rm, ra, rb);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule